// File: doc/BRIEF.md
# Multimode DDS Phase Generator

This block is the phase engine of a direct digital synthesizer. A 48-bit frequency register feeds a 48-bit phase accumulator, and a 14-bit phase offset is added to the result. The top 17 bits of that sum go to a phase-to-amplitude stage, which lies outside this block. The frequency register is set by one of five operating modes. Single tone holds a fixed frequency. Unramped FSK jumps between two tuning words. Ramped FSK slides toward the selected tuning word in fixed steps. Linear chirp sweeps upward without limit. BPSK switches between two phase offsets.

A single data pin carries a different meaning in each mode. In the FSK modes it picks the tuning word. In BPSK it picks the phase offset. In chirp it holds the sweep. A rate timer sets the spacing of the frequency steps used by ramped FSK and chirp. All programmed values sit on input buses and take effect only on a one-cycle update strobe. The present frequency word is also driven out, so that neighbouring logic can observe it.

Top module: `dds_phase_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the frequency register, the phase accumulator, `phase_out` and every programmed value, and selects single tone mode.
- R2: When `upd` is high at a clock edge, the mode, both tuning words, both offsets, the delta word and the rate value are loaded from their inputs, `freq_out` is set to the new tuning word A, and the rate timer is loaded with the new rate. While `upd` is low, changes on those inputs have no effect.
- R3: At every edge the accumulator advances by the frequency register, modulo 2^48. At the same edge, `phase_out` is registered as accumulator bits [47:31] plus the active 14-bit offset shifted left by 3, modulo 2^17. A tuning word of n·2^31 therefore raises `phase_out` by n per cycle.
- R4: Mode code 3'b000 (single tone) and the unused codes 3'b101 to 3'b111 hold `freq_out` at tuning word A and use offset A. In these modes the data pin has no effect.
- R5: In mode 3'b001 (unramped FSK), `freq_out` becomes tuning word B one edge after `data_pin` is seen high, and tuning word A one edge after it is seen low. The offset is A.
- R6: In mode 3'b100 (BPSK), the frequency is tuning word A. The offset used at an edge is B when `data_pin` is high and A when it is low.
- R7: The rate timer counts down, reloading from the rate value after it reaches zero. This gives one step opportunity every rate+1 cycles, and the first one falls rate+1 edges after the update.
- R8: In mode 3'b010 (ramped FSK), each step moves `freq_out` toward the tuning word selected by `data_pin` by the delta word. When fewer than one delta remains, the step lands exactly on the target, and the frequency never passes it in either direction.
- R9: In mode 3'b011 (chirp), each step adds the delta word to `freq_out` modulo 2^48. While `data_pin` is high at a step edge, that step is skipped, but the timer keeps running.
- R10: Outside BPSK mode, the offset is always offset A, whatever the level of `data_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| upd | input | 1 | Update strobe that loads all programmed values |
| mode_in | input | 3 | Mode code loaded on update |
| ftw_a_in | input | 48 | Tuning word A |
| ftw_b_in | input | 48 | Tuning word B |
| pofs_a_in | input | 14 | Phase offset A |
| pofs_b_in | input | 14 | Phase offset B |
| dfw_in | input | 48 | Delta frequency word for ramps and chirps |
| rate_in | input | 20 | Rate timer reload value |
| data_pin | input | 1 | Shared select / hold pin |
| freq_out | output | 48 | Present frequency register |
| phase_out | output | 17 | Truncated phase word to the amplitude stage |

## Verification
On every cycle the assertions check the following. The rate timer never exceeds its reload value. The frequency moves only on a timer step in ramp and chirp modes. A held chirp stays frozen. Ramped FSK never overshoots its target. Single tone and unramped FSK follow the selected tuning word. The bench scenarios cover what needs known stimulus and counted cycles. These are the exact edge of each ramp step, the clamp value, the 2^48 wrap of a chirp, the size of the phase jump when BPSK switches offsets, and proof that inputs presented without the strobe are ignored.

// File: rtl/dds_phase_gen.sv
module dds_phase_gen #(
  parameter int FW = 48,
  parameter int PW = 14,
  parameter int OW = 17,
  parameter int RW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [2:0]    mode_in,
  input  logic [FW-1:0] ftw_a_in,
  input  logic [FW-1:0] ftw_b_in,
  input  logic [PW-1:0] pofs_a_in,
  input  logic [PW-1:0] pofs_b_in,
  input  logic [FW-1:0] dfw_in,
  input  logic [RW-1:0] rate_in,
  input  logic          data_pin,
  output logic [FW-1:0] freq_out,
  output logic [OW-1:0] phase_out
);

  typedef enum logic [2:0] {
    M_TONE  = 3'b000,
    M_UFSK  = 3'b001,
    M_RFSK  = 3'b010,
    M_CHIRP = 3'b011,
    M_BPSK  = 3'b100
  } mode_e;

  localparam int PAD = OW - PW;

  logic [2:0]    mode;
  logic [FW-1:0] ftw_a, ftw_b, dfw, acc, freq_nx;
  logic [PW-1:0] pofs_a, pofs_b;
  logic [RW-1:0] rate, timer;

  wire           tick   = (timer == '0);
  wire [FW-1:0]  target = data_pin ? ftw_b : ftw_a;
  wire           go_up  = freq_out < target;
  wire [FW-1:0]  gap    = go_up ? target - freq_out : freq_out - target;
  wire [FW-1:0]  ramp_nx = (gap <= dfw) ? target :
                           go_up ? freq_out + dfw : freq_out - dfw;
  wire [PW-1:0]  pofs   = (mode == M_BPSK && data_pin) ? pofs_b : pofs_a;

  always_comb begin
    case (mode)
      M_UFSK:  freq_nx = target;
      M_RFSK:  freq_nx = tick ? ramp_nx : freq_out;
      M_CHIRP: freq_nx = (tick && !data_pin) ? freq_out + dfw : freq_out;
      default: freq_nx = ftw_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= M_TONE;
      ftw_a  <= '0;
      ftw_b  <= '0;
      dfw    <= '0;
      pofs_a <= '0;
      pofs_b <= '0;
      rate   <= '0;
    end else if (upd) begin
      mode   <= mode_in;
      ftw_a  <= ftw_a_in;
      ftw_b  <= ftw_b_in;
      dfw    <= dfw_in;
      pofs_a <= pofs_a_in;
      pofs_b <= pofs_b_in;
      rate   <= rate_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else if (upd || tick) begin
      timer <= upd ? rate_in : rate;
    end else begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_out  <= '0;
      acc       <= '0;
      phase_out <= '0;
    end else begin
      freq_out  <= upd ? ftw_a_in : freq_nx;
      acc       <= acc + freq_out;
      phase_out <= acc[FW-1 -: OW] + {pofs, {PAD{1'b0}}};
    end
  end

  p_timer_bound_r7: assert property (@(posedge clk) disable iff (rst)
    timer <= rate);

  p_step_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_RFSK || mode == M_CHIRP) && !upd && !tick) |=> $stable(freq_out));

  p_chirp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CHIRP && data_pin && !upd) |=> $stable(freq_out));

  p_no_overshoot_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RFSK && !upd && freq_out <= target) |=> freq_out <= $past(target));

  p_no_undershoot_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RFSK && !upd && freq_out >= target) |=> freq_out >= $past(target));

  p_tone_freq_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TONE && !upd) |=> freq_out == $past(ftw_a));

  p_fsk_select_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == M_UFSK && !upd) |=> freq_out == ($past(data_pin) ? $past(ftw_b) : $past(ftw_a)));

  p_upd_load_r2: assert property (@(posedge clk) disable iff (rst)
    upd |=> freq_out == $past(ftw_a_in));

endmodule

// File: tb/tb_dds_phase_gen.sv
module tb_dds_phase_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd = 1'b0;
  logic [2:0]  mode_in = '0;
  logic [47:0] ftw_a_in = '0, ftw_b_in = '0, dfw_in = '0;
  logic [13:0] pofs_a_in = '0, pofs_b_in = '0;
  logic [19:0] rate_in = '0;
  logic        data_pin = 1'b0;
  logic [47:0] freq_out;
  logic [16:0] phase_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dds_phase_gen dut (
    .clk(clk), .rst(rst), .upd(upd), .mode_in(mode_in),
    .ftw_a_in(ftw_a_in), .ftw_b_in(ftw_b_in),
    .pofs_a_in(pofs_a_in), .pofs_b_in(pofs_b_in),
    .dfw_in(dfw_in), .rate_in(rate_in), .data_pin(data_pin),
    .freq_out(freq_out), .phase_out(phase_out)
  );

  // entry: {mode[3:0], step_pin_low[7:0], step_pin_high[7:0], phase_jump[15:0]}
  localparam logic [35:0] VEC [0:4] = '{
    {4'd0, 8'd3, 8'd3, 16'd0},    // R4 single tone
    {4'd1, 8'd3, 8'd7, 16'd0},    // R5 unramped FSK
    {4'd4, 8'd3, 8'd3, 16'd760},  // R6 BPSK: (100-5)*8
    {4'd5, 8'd3, 8'd3, 16'd0},    // R4 unused code
    {4'd7, 8'd3, 8'd3, 16'd0}     // R10 unused code, offset A kept
  };

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic load(input logic [2:0] m);
    mode_in = m; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  initial begin
    logic [16:0] p0, p1, p2, p3;
    cyc(3);
    rst = 1'b0;
    chk("R1 reset freq", freq_out, 0);
    chk("R1 reset phase", {31'd0, phase_out}, 0);

    for (int i = 0; i < 5; i++) begin
      logic [35:0] v;
      v = VEC[i];
      do_reset();
      ftw_a_in = 48'd3 << 31; ftw_b_in = 48'd7 << 31;
      pofs_a_in = 14'd5; pofs_b_in = 14'd100;
      data_pin = 1'b0;
      load(v[34:32]);
      cyc(4);
      chk("R4/R5/R6 freq pin low", freq_out, {40'd0, v[31:24]} << 31);
      p0 = phase_out;
      data_pin = 1'b1;
      cyc(1);
      p1 = phase_out;
      chk("R3/R6/R10 phase step on pin change", {31'd0, 17'(p1 - p0)},
          {31'd0, 17'(v[31:24] + v[15:0])});
      cyc(2);
      p2 = phase_out;
      cyc(1);
      p3 = phase_out;
      chk("R4/R5 freq pin high", freq_out, {40'd0, v[23:16]} << 31);
      chk("R3 phase step pin high", {31'd0, 17'(p3 - p2)},
          {31'd0, 17'(v[23:16] + ((v[34:32] == 3'd4) ? 16'd0 : 16'd0))});
    end

    do_reset();
    ftw_a_in = 48'd3 << 31; data_pin = 1'b0;
    load(3'd0);
    ftw_a_in = 48'd999; mode_in = 3'd1; data_pin = 1'b1; ftw_b_in = 48'd5;
    cyc(3);
    chk("R2 inputs ignored without strobe", freq_out, 48'd3 << 31);

    do_reset();
    ftw_a_in = 48'd1000; ftw_b_in = 48'd1250; dfw_in = 48'd100; rate_in = 20'd3;
    data_pin = 1'b1;
    load(3'd2);
    chk("R2 strobe loads tuning word A", freq_out, 1000);
    cyc(3);
    chk("R7 no step before timer expires", freq_out, 1000);
    cyc(1);
    chk("R7 first step at rate+1", freq_out, 1100);
    cyc(8);
    chk("R8 clamp on target going up", freq_out, 1250);
    cyc(4);
    chk("R8 stays at target", freq_out, 1250);
    data_pin = 1'b0;
    cyc(4);
    chk("R8 step down", freq_out, 1150);
    cyc(8);
    chk("R8 clamp on target going down", freq_out, 1000);
    cyc(4);
    chk("R8 stays at lower target", freq_out, 1000);

    do_reset();
    ftw_a_in = 48'd2000; dfw_in = 48'd50; rate_in = 20'd1; data_pin = 1'b0;
    load(3'd3);
    cyc(2);
    chk("R9 chirp first step", freq_out, 2050);
    cyc(2);
    chk("R9 chirp second step", freq_out, 2100);
    data_pin = 1'b1;
    cyc(4);
    chk("R9 hold freezes sweep", freq_out, 2100);
    data_pin = 1'b0;
    cyc(1);
    chk("R9 no step off-tick after hold", freq_out, 2100);
    cyc(1);
    chk("R9 sweep resumes", freq_out, 2150);

    do_reset();
    ftw_a_in = 48'hFFFF_FFFF_FFFF - 48'd29; dfw_in = 48'd50; rate_in = 20'd0;
    load(3'd3);
    cyc(1);
    chk("R9 chirp wraps modulo 2^48", freq_out, 20);

    ftw_a_in = 48'd3 << 31; rate_in = 20'd1;
    load(3'd0);
    cyc(3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-run reset freq", freq_out, 0);
    chk("R1 mid-run reset phase", {31'd0, phase_out}, 0);
    cyc(3);
    chk("R1 cleared tuning word keeps freq at zero", freq_out, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule